// File: doc/BRIEF.md
# Multiplexed VFD Grid and Brightness Timer

This block drives the time-multiplexed strobing of a vacuum fluorescent display that has two or three grids sharing one set of 32 anode lines. A free-running timer divides the oscillator clock into bit-times and groups the bit-times into grid slots. Each grid is lit in its own slot, and the slots repeat in a fixed order. A duplex/triplex select input sets the number of slots in a display cycle to two or three.

Inside each slot the active grid is pulled low for a programmable number of bit-times. That number comes from a 10-bit brightness value, which is clamped a few steps below full scale. The anode outputs carry the pattern stored for the active grid. They stay on a few bit-times longer than the grid pulse so that the grid always switches off while its anodes are still driven. A dimming pulse output follows the grid on-time.

A host loads anode patterns through a parallel write port. A 2-bit code picks one grid's store, or all three at once. The host loads the brightness value through a separate strobe. Written values are staged. They reach the outputs only at the next slot boundary, so no pulse is ever cut short or changed partway through a slot.

Top module: `vfd_mux_timer`

## Requirements
- R1: While `rst_n` is low and after it is released, `grid_n` is 3'b111, `seg` is all zero and `dim_pulse` is 0. The brightness value and all three anode stores start at zero.
- R2: One bit-time is `CLKS_PER_BIT` clocks and one grid slot is `SLOT_BITS` bit-times. The first slot starts at the first clock edge after reset release. The active grid changes only at slot boundaries.
- R3: With `duplex_sel` high, slots alternate grid1, grid2, grid1, and so on. `grid_n[2]` is never driven low.
- R4: With `duplex_sel` low, slots run grid1, grid2, grid3 and then repeat.
- R5: In each slot, the active grid's `grid_n` bit is low for the first D bit-times, where D is the applied brightness value. All other bits stay high. At most one grid is low at any time.
- R6: A written brightness value larger than `DIM_MAX` (1016 by default, 56 in the bench configuration) behaves exactly as `DIM_MAX`. The value 0 keeps every grid off.
- R7: `seg` equals the applied anode store of the active grid for the first D+`SEG_TAIL` bit-times of the slot, and is zero for the rest of the slot. A 1 in the store drives the matching output high.
- R8: A write with `wr_en` high and `wr_code` 1, 2 or 3 loads `wr_data` into the store of grid1, grid2 or grid3 respectively. `wr_code` 0 loads the same data into all three stores.
- R9: `dim_pulse` is high exactly while some grid is low.
- R10: A store or brightness write captured at a clock edge before a slot's first edge applies from that slot onward. A write captured at the slot's first edge waits for the following slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duplex_sel | input | 1 | 1 = two grids per cycle, 0 = three grids |
| wr_en | input | 1 | Anode store write strobe |
| wr_code | input | 2 | 0 = all stores, 1..3 = grid1..grid3 store |
| wr_data | input | SEG_W | Anode pattern to write |
| dim_wr_en | input | 1 | Brightness write strobe |
| dim_value | input | BIT_W | Brightness in bit-times per slot |
| grid_n | output | 3 | Grid strobes, active low |
| seg | output | SEG_W | Anode outputs, active high |
| dim_pulse | output | 1 | High during the grid on-time |

## Verification
The bench builds the block with two clocks per bit-time, 64 bit-times per slot, an 8-bit anode width and a clamp at 56. With these values a full slot lasts 128 clocks, so every clock of seven consecutive slots can be compared against arithmetic expectations in both duplex and triplex modes. The smaller configuration also puts the zero value, the clamp boundary, the top code of the brightness field and writes landing one clock either side of a slot boundary within a short run.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  localparam int NUM_GRIDS = 3;

  // Store selection codes on the host write port.
  typedef enum logic [1:0] {
    WR_ALL = 2'd0,
    WR_G1  = 2'd1,
    WR_G2  = 2'd2,
    WR_G3  = 2'd3
  } wr_code_e;

  typedef logic [1:0] grid_idx_t;

endpackage

// File: rtl/vfd_bit_timer.sv
module vfd_bit_timer #(
  parameter int CLKS_PER_BIT = 4,
  parameter int SLOT_BITS    = 1024,
  localparam int BIT_W       = $clog2(SLOT_BITS),
  localparam int PRE_W       = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   duplex_sel,
  output logic [BIT_W-1:0]       bit_pos,
  output vfd_pkg::grid_idx_t     grid_idx,
  output logic                   slot_load
);

  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_BIT - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

  logic [PRE_W-1:0]   pre_q, pre_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  vfd_pkg::grid_idx_t idx_q, idx_d;
  vfd_pkg::grid_idx_t idx_last;
  logic               bit_tick;

  assign bit_tick  = (pre_q == PRE_LAST);
  assign slot_load = bit_tick && (bit_q == BIT_LAST);
  assign idx_last  = duplex_sel ? 2'd1 : 2'd2;

  always_comb begin
    pre_d = pre_q;
    bit_d = bit_q;
    idx_d = idx_q;
    if (bit_tick) begin
      pre_d = '0;
      bit_d = (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
    if (slot_load) begin
      idx_d = (idx_q >= idx_last) ? 2'd0 : idx_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      bit_q <= '0;
      idx_q <= '0;
    end else begin
      pre_q <= pre_d;
      bit_q <= bit_d;
      idx_q <= idx_d;
    end
  end

  assign bit_pos  = bit_q;
  assign grid_idx = idx_q;

endmodule

// File: rtl/vfd_latch_bank.sv
module vfd_latch_bank #(
  parameter int SEG_W   = 32,
  parameter int DIM_W   = 10,
  parameter int DIM_MAX = 1016
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     wr_en,
  input  logic [1:0]                               wr_code,
  input  logic [SEG_W-1:0]                         wr_data,
  input  logic                                     dim_wr_en,
  input  logic [DIM_W-1:0]                         dim_value,
  input  logic                                     slot_load,
  output logic [vfd_pkg::NUM_GRIDS-1:0][SEG_W-1:0] seg_act,
  output logic [DIM_W-1:0]                         dim_act
);

  localparam logic [DIM_W-1:0] DIM_CAP = DIM_W'(DIM_MAX);

  // Brightness: staged copy is clamped on entry, applied copy follows at slot start.
  logic [DIM_W-1:0] dim_stg_q, dim_stg_d;
  logic [DIM_W-1:0] dim_act_q, dim_act_d;

  always_comb begin
    dim_stg_d = dim_stg_q;
    if (dim_wr_en) begin
      dim_stg_d = (dim_value > DIM_CAP) ? DIM_CAP : dim_value;
    end
    dim_act_d = slot_load ? dim_stg_q : dim_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dim_stg_q <= '0;
      dim_act_q <= '0;
    end else begin
      dim_stg_q <= dim_stg_d;
      dim_act_q <= dim_act_d;
    end
  end

  assign dim_act = dim_act_q;

  // One staged and one applied anode store per grid.
  for (genvar g = 0; g < vfd_pkg::NUM_GRIDS; g++) begin : g_store
    logic             hit;
    logic [SEG_W-1:0] stg_q, stg_d;
    logic [SEG_W-1:0] act_q, act_d;

    assign hit = wr_en && ((wr_code == vfd_pkg::WR_ALL) || (wr_code == 2'(g + 1)));

    always_comb begin
      stg_d = hit ? wr_data : stg_q;
      act_d = slot_load ? stg_q : act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= '0;
        act_q <= '0;
      end else begin
        stg_q <= stg_d;
        act_q <= act_d;
      end
    end

    assign seg_act[g] = act_q;
  end

endmodule

// File: rtl/vfd_pulse_gen.sv
module vfd_pulse_gen #(
  parameter int SEG_W    = 32,
  parameter int BIT_W    = 10,
  parameter int SEG_TAIL = 3
) (
  input  logic [BIT_W-1:0]                         bit_pos,
  input  vfd_pkg::grid_idx_t                       grid_idx,
  input  logic [BIT_W-1:0]                         dim_act,
  input  logic [vfd_pkg::NUM_GRIDS-1:0][SEG_W-1:0] seg_act,
  output logic [vfd_pkg::NUM_GRIDS-1:0]            grid_n,
  output logic [SEG_W-1:0]                         seg,
  output logic                                     dim_pulse
);

  localparam int CMP_W = BIT_W + 1;

  logic [CMP_W-1:0] pos_w;
  logic [CMP_W-1:0] grid_end;
  logic [CMP_W-1:0] seg_end;
  logic             grid_on;
  logic             seg_on;
  logic [SEG_W-1:0] seg_pick;

  assign pos_w    = {1'b0, bit_pos};
  assign grid_end = {1'b0, dim_act};
  assign seg_end  = grid_end + CMP_W'(SEG_TAIL);
  assign grid_on  = (pos_w < grid_end);
  assign seg_on   = (pos_w < seg_end);

  always_comb begin
    seg_pick = '0;
    for (int g = 0; g < vfd_pkg::NUM_GRIDS; g++) begin
      if (grid_idx == 2'(g)) begin
        seg_pick = seg_act[g];
      end
    end
  end

  for (genvar g = 0; g < vfd_pkg::NUM_GRIDS; g++) begin : g_strobe
    assign grid_n[g] = ~(grid_on && (grid_idx == 2'(g)));
  end

  assign seg       = seg_on ? seg_pick : '0;
  assign dim_pulse = grid_on;

endmodule

// File: rtl/vfd_mux_timer.sv
module vfd_mux_timer #(
  parameter int CLKS_PER_BIT = 4,
  parameter int SLOT_BITS    = 1024,
  parameter int SEG_W        = 32,
  parameter int DIM_MAX      = 1016,
  parameter int SEG_TAIL     = 3,
  localparam int BIT_W       = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              duplex_sel,
  input  logic              wr_en,
  input  logic [1:0]        wr_code,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              dim_wr_en,
  input  logic [BIT_W-1:0]  dim_value,
  output logic [2:0]        grid_n,
  output logic [SEG_W-1:0]  seg,
  output logic              dim_pulse
);

  logic [BIT_W-1:0]                         bit_pos;
  vfd_pkg::grid_idx_t                       grid_idx;
  logic                                     slot_load;
  logic [vfd_pkg::NUM_GRIDS-1:0][SEG_W-1:0] seg_act;
  logic [BIT_W-1:0]                         dim_act;

  vfd_bit_timer #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .SLOT_BITS    (SLOT_BITS)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .duplex_sel (duplex_sel),
    .bit_pos    (bit_pos),
    .grid_idx   (grid_idx),
    .slot_load  (slot_load)
  );

  vfd_latch_bank #(
    .SEG_W   (SEG_W),
    .DIM_W   (BIT_W),
    .DIM_MAX (DIM_MAX)
  ) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_code   (wr_code),
    .wr_data   (wr_data),
    .dim_wr_en (dim_wr_en),
    .dim_value (dim_value),
    .slot_load (slot_load),
    .seg_act   (seg_act),
    .dim_act   (dim_act)
  );

  vfd_pulse_gen #(
    .SEG_W    (SEG_W),
    .BIT_W    (BIT_W),
    .SEG_TAIL (SEG_TAIL)
  ) pulse_i (
    .bit_pos   (bit_pos),
    .grid_idx  (grid_idx),
    .dim_act   (dim_act),
    .seg_act   (seg_act),
    .grid_n    (grid_n),
    .seg       (seg),
    .dim_pulse (dim_pulse)
  );

endmodule

// File: rtl/vfd_mux_checker.sv
module vfd_mux_checker #(
  parameter int PERIOD  = 4096,
  parameter int BIT_W   = 10,
  parameter int DIM_MAX = 1016
) (
  input logic             clk,
  input logic             rst_n,
  input logic             duplex_sel,
  input logic [2:0]       grid_n,
  input logic             dim_pulse,
  input logic             slot_load,
  input logic [1:0]       grid_idx,
  input logic [BIT_W-1:0] dim_act
);

  // Clocks since the last slot boundary, for the slot length check.
  logic [31:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (slot_load) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + 32'd1;
    end
  end

  a_r2_slot_length : assert property (@(posedge clk) disable iff (!rst_n)
    slot_load |-> (gap_q == 32'(PERIOD - 1)));

  a_r3_duplex_two_slots : assert property (@(posedge clk) disable iff (!rst_n)
    (slot_load && duplex_sel) |=> (grid_idx != 2'd2));

  a_r4_index_range : assert property (@(posedge clk) disable iff (!rst_n)
    grid_idx != 2'd3);

  a_r5_single_grid : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grid_n));

  a_r6_dim_clamped : assert property (@(posedge clk) disable iff (!rst_n)
    dim_act <= BIT_W'(DIM_MAX));

  a_r9_pulse_tracks_grid : assert property (@(posedge clk) disable iff (!rst_n)
    dim_pulse == (grid_n != 3'b111));

  a_r10_dim_held_in_slot : assert property (@(posedge clk) disable iff (!rst_n)
    !slot_load |=> $stable(dim_act));

endmodule

bind vfd_mux_timer vfd_mux_checker #(
  .PERIOD  (CLKS_PER_BIT * SLOT_BITS),
  .BIT_W   (BIT_W),
  .DIM_MAX (DIM_MAX)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .duplex_sel (duplex_sel),
  .grid_n     (grid_n),
  .dim_pulse  (dim_pulse),
  .slot_load  (slot_load),
  .grid_idx   (grid_idx),
  .dim_act    (dim_act)
);

// File: tb/vfd_mux_timer_tb_top.sv
module vfd_mux_timer_tb_top;

  localparam int C    = 2;
  localparam int S    = 64;
  localparam int W    = 8;
  localparam int DMAX = 56;
  localparam int TAIL = 3;
  localparam int P    = C * S;
  localparam int BW   = $clog2(S);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          duplex_sel;
  logic          wr_en;
  logic [1:0]    wr_code;
  logic [W-1:0]  wr_data;
  logic          dim_wr_en;
  logic [BW-1:0] dim_value;
  logic [2:0]    grid_n;
  logic [W-1:0]  seg;
  logic          dim_pulse;

  int  vectors = 0;
  int  errors  = 0;
  bit  done    = 1'b0;

  // Write captured at the next edge; folded into the staged model one iteration later.
  bit         p_seg_en;
  int         p_code;
  logic [W-1:0] p_data;
  bit         p_dim_en;
  int         p_dim;

  always #5 clk = ~clk;

  vfd_mux_timer #(
    .CLKS_PER_BIT (C),
    .SLOT_BITS    (S),
    .SEG_W        (W),
    .DIM_MAX      (DMAX),
    .SEG_TAIL     (TAIL)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .duplex_sel (duplex_sel),
    .wr_en      (wr_en),
    .wr_code    (wr_code),
    .wr_data    (wr_data),
    .dim_wr_en  (dim_wr_en),
    .dim_value  (dim_value),
    .grid_n     (grid_n),
    .seg        (seg),
    .dim_pulse  (dim_pulse)
  );

  task automatic check(input string tag, input int n, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at clock %0d: actual %h expected %h", tag, n, act, exp);
    end
  endtask

  task automatic put_seg(input int code, input logic [W-1:0] data);
    wr_en    = 1'b1;
    wr_code  = 2'(code);
    wr_data  = data;
    p_seg_en = 1'b1;
    p_code   = code;
    p_data   = data;
  endtask

  task automatic put_dim(input int v);
    dim_wr_en = 1'b1;
    dim_value = BW'(v);
    p_dim_en  = 1'b1;
    p_dim     = v;
  endtask

  task automatic run_case(input bit dup, input int dim_a, input int dim_b);
    int           act_dim;
    int           stg_dim;
    logic [W-1:0] act_seg [3];
    logic [W-1:0] stg_seg [3];
    rst_n      = 1'b0;
    duplex_sel = dup;
    wr_en      = 1'b0;
    wr_code    = 2'd0;
    wr_data    = '0;
    dim_wr_en  = 1'b0;
    dim_value  = '0;
    p_seg_en   = 1'b0;
    p_dim_en   = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state while reset is held
    check("R1 grid_n", 0, 32'(grid_n), 32'h7);
    check("R1 seg", 0, 32'(seg), 32'h0);
    check("R1 dim_pulse", 0, 32'(dim_pulse), 32'h0);
    rst_n   = 1'b1;
    act_dim = 0;
    stg_dim = 0;
    for (int g = 0; g < 3; g++) begin
      act_seg[g] = '0;
      stg_seg[g] = '0;
    end
    for (int n = 0; n < 7 * P; n++) begin
      int           s;
      int           b;
      int           g;
      logic [2:0]   exp_grid;
      logic [W-1:0] exp_seg;
      bit           on;
      // R10: applied values switch at each slot start edge
      if (n > 0 && (n % P) == 0) begin
        act_dim = stg_dim;
        for (int k = 0; k < 3; k++) act_seg[k] = stg_seg[k];
      end
      // R8: store selection by code; R6: clamp
      if (p_seg_en) begin
        for (int k = 0; k < 3; k++)
          if (p_code == 0 || p_code == k + 1) stg_seg[k] = p_data;
        p_seg_en = 1'b0;
      end
      if (p_dim_en) begin
        stg_dim  = (p_dim > DMAX) ? DMAX : p_dim;
        p_dim_en = 1'b0;
      end
      // R2: slot and bit position from elapsed clocks
      s  = n / P;
      b  = (n / C) % S;
      g  = s % (dup ? 2 : 3);
      on = (b < act_dim);
      exp_grid = on ? (3'b111 & ~(3'b001 << g)) : 3'b111;
      exp_seg  = (b < act_dim + TAIL) ? act_seg[g] : '0;
      check(dup ? "R2/R3/R5 grid_n" : "R2/R4/R5 grid_n", n, 32'(grid_n), 32'(exp_grid));
      check("R7/R8/R10 seg", n, 32'(seg), 32'(exp_seg));
      check("R6/R9/R10 dim_pulse", n, 32'(dim_pulse), 32'(on));
      wr_en     = 1'b0;
      dim_wr_en = 1'b0;
      if (n == 10) begin
        put_seg(0, 8'hA5);
        put_dim(dim_a);
      end else if (n == 11) begin
        put_seg(2, 8'h3C);
      end else if (n == 12) begin
        put_seg(3, 8'hC3);
      end else if (n == 2 * P + 40) begin
        put_seg(1, 8'h0F);
        put_dim(dim_b);
      end else if (n == 4 * P - 2) begin
        put_seg(0, 8'hFF);
      end else if (n == 4 * P - 1) begin
        put_dim(dim_a);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    run_case(1'b1, 5, 56);
    run_case(1'b0, 0, 63);
    run_case(1'b0, 1, 57);
    run_case(1'b1, 63, 20);
    run_case(1'b0, 32, 55);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule